// File: doc/BRIEF.md
# Compare-Match Event Timer Channel

This block is one up-counting timer channel that produces timer interrupts from a slow tick, typically a 32.768 kHz reference delivered as single-cycle enable pulses in the system clock domain. A selectable tick source advances a 16-bit counter. A compare value sets the point where a compare event fires. The same hardware gives a periodic tick and a one-shot delay. In periodic use, the counter returns to zero after each compare and keeps running. In one-shot use, a stop-on-compare setting also halts the counter at the compare value.

Software programs the mode (tick source, stop-on-compare, reset-on-compare), loads the compare value, and then issues a start command. The start command combines enable and trigger, and it clears the counter and starts it. Event flags are sticky and clear when the status is read. An interrupt enable mask decides which flags drive the interrupt line. A periodic reload for a tick rate HZ is normally (32768 + HZ/2)/HZ. Computing that value is left to software. The longest delay is 0xFFFF ticks, about two seconds, and the shortest is one tick.

Top module: `tc_event_channel`

## Requirements
- R1: With reset-on-compare set and stop-on-compare clear, a running counter steps 0,1,…,RC,0,1,… on each selected tick. Each step onto RC sets the compare flag (status bit 0), so a compare fires every RC+1 ticks.
- R2: With stop-on-compare set, the tick that brings the counter to RC sets the compare flag and stops the counter. It holds at RC and ignores further ticks until a new start.
- R3: A control write with trigger set forces the counter to 0. Trigger together with enable also starts counting. Trigger alone on a stopped channel leaves it stopped.
- R4: A control write with disable stops counting. While stopped, the count value does not change on ticks.
- R5: The interrupt line is high exactly when some flag is set and its enable-mask bit is set. An enable write sets mask bits and a disable write clears them. Writing all ones to the disable register masks every source while the flags stay visible in status.
- R6: When enable and disable arrive in the same control write, the channel ends up stopped.
- R7: A status read clears all flags on the next cycle. A compare event in the same cycle as the read leaves its flag set.
- R8: Writing RC while the counter is stopped does not start it. Only a start command does.
- R9: With reset-on-compare clear, reaching RC sets the compare flag without resetting the count. Stepping past 0xFFFF wraps to 0 and sets the overflow flag (status bit 1).
- R10: Only pulses on the tick source chosen by the mode's source field advance the counter. Pulses on other sources have no effect.
- R11: In one-shot mode with RC = 0xFFFF, the counter runs the full 0xFFFF ticks, then fires and halts at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_src | input | N_SRC | Tick enable pulses, one per source |
| mode_wr | input | 1 | Mode register write strobe |
| mode_sel | input | $clog2(N_SRC) | Tick source index |
| mode_stop | input | 1 | Stop-on-compare setting |
| mode_auto | input | 1 | Reset-on-compare setting |
| rc_wr | input | 1 | Compare value write strobe |
| rc_data | input | CNT_W | Compare value |
| ctl_wr | input | 1 | Control command strobe |
| ctl_en | input | 1 | Enable counting |
| ctl_dis | input | 1 | Disable counting (wins over enable) |
| ctl_trig | input | 1 | Clear the counter (with enable: start) |
| ier_wr | input | 1 | Interrupt-enable write strobe |
| ier_data | input | 2 | Mask bits to set |
| idr_wr | input | 1 | Interrupt-disable write strobe |
| idr_data | input | 2 | Mask bits to clear |
| sr_rd | input | 1 | Status read strobe (clears flags) |
| status | output | 2 | Sticky flags: bit 0 compare, bit 1 overflow |
| irq | output | 1 | Interrupt request |
| count | output | CNT_W | Current counter value |
| running | output | 1 | Counter clock enabled |

## Verification
The assertions check some properties on every cycle: a one-shot compare halts the counter, disable wins over enable, a stopped counter holds its value, the counter wraps to zero after RC in reset-on-compare mode, an RC write never starts the counter, a read with no event clears the flags, and masking all sources drops the interrupt. The bench scenarios cover the rest. They give the exact tick counts between compares across a sweep of RC values in both modes, and the same-cycle race between a read and a new event. They also cover the overflow wrap after a full 16-bit run, the longest one-shot delay, and the isolation of unselected tick sources.

// File: rtl/tc_evt_pkg.sv
// Package: shared constants and command type for the event timer channel.
// Assumes flag bit positions are fixed: compare in bit 0, overflow in bit 1.
package tc_evt_pkg;
    localparam int STAT_W  = 2;
    localparam int CMP_BIT = 0;
    localparam int OVF_BIT = 1;

    typedef struct packed {
        logic en;
        logic dis;
        logic trig;
    } ctl_cmd_t;
endpackage

// File: rtl/tc_tick_sel.sv
// Tick source selector: holds the source index from the mode register and
// forwards the chosen tick pulse. Assumes the ticks are single-cycle enables
// that are already synchronous to clk.
module tc_tick_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             mode_wr,
    input  logic [SEL_W-1:0] mode_sel,
    output logic             tick
);
    logic [SEL_W-1:0] sel_q;

    // Capture the source index on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (mode_wr) sel_q <= mode_sel;
    end

    generate
        if ((1 << SEL_W) == N_SRC) begin : g_pow2
            // Every index is valid: plain mux.
            always_comb tick = tick_src[sel_q];
        end else begin : g_range
            // Indices past the last source select no tick.
            always_comb tick = (32'(sel_q) < N_SRC) ? tick_src[sel_q] : 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tc_counter.sv
// Counter core: up-counter with compare, reset-on-compare and
// stop-on-compare, started and stopped by control commands.
// Assumes a control write takes the whole cycle: no tick step that cycle.
module tc_counter
    import tc_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode_wr,
    input  logic             mode_stop,
    input  logic             mode_auto,
    input  logic             rc_wr,
    input  logic [CNT_W-1:0] rc_data,
    input  logic             ctl_wr,
    input  ctl_cmd_t         ctl_cmd,
    output logic [CNT_W-1:0] cnt,
    output logic             clk_on,
    output logic             cmp_hit,
    output logic             ovf_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             stop_q, auto_q;
    logic [CNT_W-1:0] rc_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;

    // Hold the stop and reset-on-compare settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            auto_q <= 1'b0;
        end else if (mode_wr) begin
            stop_q <= mode_stop;
            auto_q <= mode_auto;
        end
    end

    // Hold the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)     rc_q <= '0;
        else if (rc_wr) rc_q <= rc_data;
    end

    // Work out the next count and which events this step raises.
    always_comb begin
        step    = clk_on && tick && !ctl_wr;
        cnt_nxt = (auto_q && cnt == rc_q) ? '0 : cnt + 1'b1;
        cmp_hit = step && (cnt_nxt == rc_q);
        ovf_hit = step && !auto_q && (cnt == CNT_MAX);
    end

    // Counter and clock-enable state; control commands come first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            clk_on <= 1'b0;
        end else if (ctl_wr) begin
            if (ctl_cmd.dis)      clk_on <= 1'b0;
            else if (ctl_cmd.en)  clk_on <= 1'b1;
            if (ctl_cmd.trig)     cnt    <= '0;
        end else if (step) begin
            cnt <= cnt_nxt;
            if (cmp_hit && stop_q) clk_on <= 1'b0;
        end
    end

    // R2: a compare in stop mode leaves the counter halted.
    a_r2_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && stop_q) |=> !clk_on);

    // R6: disable wins over enable in the same command.
    a_r6_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_cmd.dis) |=> !clk_on);

    // R4: a stopped counter holds its value without a command.
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_on && !ctl_wr) |=> $stable(cnt));

    // R1: in reset-on-compare mode the step after RC lands on zero.
    a_r1_wrap_after_rc: assert property (@(posedge clk) disable iff (!rst_n)
        (step && auto_q && cnt == rc_q) |=> (cnt == '0));
endmodule

// File: rtl/tc_irq_ctl.sv
// Flag and interrupt logic: sticky event flags cleared on status read,
// an enable mask set and cleared by separate writes, and the interrupt line.
// Assumes events and the read may land in the same cycle; the event wins.
module tc_irq_ctl
    import tc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_hit,
    input  logic              ovf_hit,
    input  logic              ier_wr,
    input  logic [STAT_W-1:0] ier_data,
    input  logic              idr_wr,
    input  logic [STAT_W-1:0] idr_data,
    input  logic              sr_rd,
    output logic [STAT_W-1:0] flags,
    output logic              irq
);
    logic [STAT_W-1:0] evt;
    logic [STAT_W-1:0] mask_q;

    // Gather the event sources into flag positions.
    always_comb begin
        evt          = '0;
        evt[CMP_BIT] = cmp_hit;
        evt[OVF_BIT] = ovf_hit;
    end

    generate
        for (genvar b = 0; b < STAT_W; b++) begin : g_flag
            // Sticky flag: a read clears it, an event in the same cycle sets it.
            always_ff @(posedge clk) begin
                if (!rst_n)      flags[b] <= 1'b0;
                else if (evt[b]) flags[b] <= 1'b1;
                else if (sr_rd)  flags[b] <= 1'b0;
            end

            // Mask bit: disable write wins over enable write.
            always_ff @(posedge clk) begin
                if (!rst_n)                      mask_q[b] <= 1'b0;
                else if (idr_wr && idr_data[b])  mask_q[b] <= 1'b0;
                else if (ier_wr && ier_data[b])  mask_q[b] <= 1'b1;
            end
        end
    endgenerate

    // Interrupt whenever an enabled flag is pending.
    always_comb irq = |(flags & mask_q);

    // R7: a read with no new event leaves every flag clear.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd && !cmp_hit && !ovf_hit) |=> (flags == '0));

    // R5: masking every source drops the interrupt line.
    a_r5_mask_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idr_wr && idr_data == {STAT_W{1'b1}}) |=> !irq);
endmodule

// File: rtl/tc_event_channel.sv
// Top of the compare-match event timer channel: ties the tick selector,
// the counter core and the flag/interrupt logic together.
// Assumes all strobes are single-cycle and synchronous to clk.
module tc_event_channel
    import tc_evt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         tick_src,
    input  logic                     mode_wr,
    input  logic [$clog2(N_SRC)-1:0] mode_sel,
    input  logic                     mode_stop,
    input  logic                     mode_auto,
    input  logic                     rc_wr,
    input  logic [CNT_W-1:0]         rc_data,
    input  logic                     ctl_wr,
    input  logic                     ctl_en,
    input  logic                     ctl_dis,
    input  logic                     ctl_trig,
    input  logic                     ier_wr,
    input  logic [STAT_W-1:0]        ier_data,
    input  logic                     idr_wr,
    input  logic [STAT_W-1:0]        idr_data,
    input  logic                     sr_rd,
    output logic [STAT_W-1:0]        status,
    output logic                     irq,
    output logic [CNT_W-1:0]         count,
    output logic                     running
);
    logic     tick;
    logic     cmp_hit, ovf_hit;
    ctl_cmd_t cmd;

    // Pack the control strobes into one command.
    always_comb cmd = '{en: ctl_en, dis: ctl_dis, trig: ctl_trig};

    tc_tick_sel #(.N_SRC(N_SRC)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_src (tick_src),
        .mode_wr  (mode_wr),
        .mode_sel (mode_sel),
        .tick     (tick)
    );

    tc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode_wr   (mode_wr),
        .mode_stop (mode_stop),
        .mode_auto (mode_auto),
        .rc_wr     (rc_wr),
        .rc_data   (rc_data),
        .ctl_wr    (ctl_wr),
        .ctl_cmd   (cmd),
        .cnt       (count),
        .clk_on    (running),
        .cmp_hit   (cmp_hit),
        .ovf_hit   (ovf_hit)
    );

    tc_irq_ctl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_hit  (cmp_hit),
        .ovf_hit  (ovf_hit),
        .ier_wr   (ier_wr),
        .ier_data (ier_data),
        .idr_wr   (idr_wr),
        .idr_data (idr_data),
        .sr_rd    (sr_rd),
        .flags    (status),
        .irq      (irq)
    );

    // R8: loading RC on a stopped channel does not start it.
    a_r8_rc_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_wr && !running && !ctl_wr) |=> !running);
endmodule

// File: tb/test_tc_event_channel.sv
module test_tc_event_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_src = '0;
    logic        mode_wr = 0, mode_stop = 0, mode_auto = 0;
    logic [1:0]  mode_sel = '0;
    logic        rc_wr = 0;
    logic [15:0] rc_data = '0;
    logic        ctl_wr = 0, ctl_en = 0, ctl_dis = 0, ctl_trig = 0;
    logic        ier_wr = 0, idr_wr = 0, sr_rd = 0;
    logic [1:0]  ier_data = '0, idr_data = '0;
    logic [1:0]  status;
    logic        irq, running;
    logic [15:0] count;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tc_event_channel i_tc_event_channel (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .mode_stop(mode_stop), .mode_auto(mode_auto),
        .rc_wr(rc_wr), .rc_data(rc_data),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_dis(ctl_dis), .ctl_trig(ctl_trig),
        .ier_wr(ier_wr), .ier_data(ier_data), .idr_wr(idr_wr), .idr_data(idr_data),
        .sr_rd(sr_rd), .status(status), .irq(irq), .count(count), .running(running)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick_on(int idx);
        @(negedge clk) tick_src[idx] = 1'b1;
        @(negedge clk) tick_src[idx] = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick_on(0);
    endtask

    task automatic tick_hold(int n);
        @(negedge clk) tick_src[0] = 1'b1;
        repeat (n) @(negedge clk);
        tick_src[0] = 1'b0;
    endtask

    task automatic set_mode(int sel, bit stop, bit autor);
        @(negedge clk) begin mode_wr = 1; mode_sel = 2'(sel); mode_stop = stop; mode_auto = autor; end
        @(negedge clk) mode_wr = 0;
    endtask

    task automatic set_rc(int v);
        @(negedge clk) begin rc_wr = 1; rc_data = 16'(v); end
        @(negedge clk) rc_wr = 0;
    endtask

    task automatic ctl(bit en, bit dis, bit trig);
        @(negedge clk) begin ctl_wr = 1; ctl_en = en; ctl_dis = dis; ctl_trig = trig; end
        @(negedge clk) begin ctl_wr = 0; ctl_en = 0; ctl_dis = 0; ctl_trig = 0; end
    endtask

    task automatic wr_ier(int d);
        @(negedge clk) begin ier_wr = 1; ier_data = 2'(d); end
        @(negedge clk) ier_wr = 0;
    endtask

    task automatic wr_idr(int d);
        @(negedge clk) begin idr_wr = 1; idr_data = 2'(d); end
        @(negedge clk) idr_wr = 0;
    endtask

    task automatic rd_sr();
        @(negedge clk) sr_rd = 1;
        @(negedge clk) sr_rd = 0;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset count", int'(count), 0);
        chk("reset status", int'(status), 0);
        chk("reset irq", int'(irq), 0);
        chk("reset running", int'(running), 0);

        // R1 + R5: periodic sweep, compare every rc+1 ticks, interrupt follows flag
        wr_ier(1);
        for (int rc = 1; rc <= 6; rc++) begin
            set_mode(0, 0, 1);
            set_rc(rc);
            ctl(1, 0, 1);
            rd_sr();
            chk("R3 start count", int'(count), 0);
            chk("R3 start running", int'(running), 1);
            for (int k = 1; k <= 3 * (rc + 1); k++) begin
                tick_on(0);
                chk("R1 periodic count", int'(count), k % (rc + 1));
                if (k % (rc + 1) == rc) begin
                    chk("R1 compare flag", int'(status[0]), 1);
                    chk("R5 irq on flag", int'(irq), 1);
                    rd_sr();
                    chk("R7 read clears", int'(status), 0);
                end else begin
                    chk("R1 no early flag", int'(status[0]), 0);
                end
            end
        end

        // R2: one-shot sweep, halt at rc, re-arm by start
        for (int rc = 1; rc <= 6; rc++) begin
            set_mode(0, 1, 1);
            set_rc(rc);
            ctl(1, 0, 1);
            rd_sr();
            ticks(rc - 1);
            chk("R2 before compare running", int'(running), 1);
            chk("R2 no flag yet", int'(status[0]), 0);
            ticks(1);
            chk("R2 flag", int'(status[0]), 1);
            chk("R2 halted", int'(running), 0);
            chk("R2 count at rc", int'(count), rc);
            ticks(2);
            chk("R2 held count", int'(count), rc);
            ctl(1, 0, 1);
            chk("R2 re-armed count", int'(count), 0);
            chk("R2 re-armed running", int'(running), 1);
            ctl(0, 1, 0);
            rd_sr();
        end

        // R5: mask all, then re-enable
        set_mode(0, 0, 1);
        set_rc(2);
        ctl(1, 0, 1);
        ticks(2);
        chk("R5 irq before mask", int'(irq), 1);
        wr_idr(3);
        chk("R5 irq masked", int'(irq), 0);
        chk("R5 flag kept", int'(status[0]), 1);
        wr_ier(1);
        chk("R5 irq unmasked", int'(irq), 1);
        rd_sr();
        chk("R5 irq after clear", int'(irq), 0);

        // R3: trigger mid-count restarts; trigger alone on stopped channel
        set_rc(20);
        ctl(1, 0, 1);
        ticks(7);
        chk("R3 mid count", int'(count), 7);
        ctl(1, 0, 1);
        chk("R3 restart count", int'(count), 0);
        ticks(3);
        // R4: disable holds
        ctl(0, 1, 0);
        chk("R4 stopped", int'(running), 0);
        ticks(4);
        chk("R4 count held", int'(count), 3);
        ctl(0, 0, 1);
        chk("R3 trig alone clears", int'(count), 0);
        chk("R3 trig alone stays off", int'(running), 0);
        ticks(2);
        chk("R3 trig alone no count", int'(count), 0);

        // R6: enable + disable together
        ctl(1, 1, 0);
        chk("R6 dis wins", int'(running), 0);

        // R8: RC write while stopped
        set_rc(4);
        chk("R8 still stopped", int'(running), 0);
        ticks(3);
        chk("R8 count unchanged", int'(count), 0);

        // R7: event in the same cycle as the read wins
        set_rc(3);
        ctl(1, 0, 1);
        ticks(2);
        rd_sr();
        @(negedge clk) begin tick_src[0] = 1; sr_rd = 1; end
        @(negedge clk) begin tick_src[0] = 0; sr_rd = 0; end
        chk("R7 event wins over read", int'(status[0]), 1);
        rd_sr();
        chk("R7 cleared after read", int'(status), 0);

        // R10: only the selected source advances
        set_mode(2, 0, 1);
        set_rc(10);
        ctl(1, 0, 1);
        for (int i = 0; i < 3; i++) tick_on(0);
        tick_on(1);
        tick_on(3);
        chk("R10 other sources ignored", int'(count), 0);
        tick_on(2);
        tick_on(2);
        chk("R10 selected source", int'(count), 2);

        // R9: free-run, compare without reset, overflow wrap
        set_mode(0, 0, 0);
        set_rc(5);
        ctl(1, 0, 1);
        rd_sr();
        ticks(5);
        chk("R9 compare flag", int'(status), 1);
        ticks(1);
        chk("R9 no reset at rc", int'(count), 6);
        rd_sr();
        tick_hold(65530);
        chk("R9 wrapped count", int'(count), 0);
        chk("R9 overflow only", int'(status), 2);
        chk("R9 still running", int'(running), 1);
        rd_sr();

        // R11: longest one-shot delay
        set_mode(0, 1, 1);
        set_rc(16'hFFFF);
        ctl(1, 0, 1);
        tick_hold(65534);
        chk("R11 before last tick", int'(count), 65534);
        chk("R11 no flag yet", int'(status[0]), 0);
        tick_hold(1);
        chk("R11 flag", int'(status[0]), 1);
        chk("R11 halted", int'(running), 0);
        tick_hold(10);
        chk("R11 held max", int'(count), 65535);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule